// File: doc/BRIEF.md
# Paged register address composer

This block turns a host-supplied 6-bit register address into the effective internal address of a peripheral. It holds a paging control register. When the register's enable flag is set, its 3-bit page field replaces the upper three bits of the host address and the host supplies only the low three bits. When the flag is clear, the host address passes through whole. The host address can come from address pins or from an internal address latch; this block does not care which.

The paging register can be reached at every effective address whose low three bits are zero. Whatever page is selected, the host can therefore always reprogram paging. A small command register sits at effective address 0x01. It holds a 6-bit command code and shows a read-only busy flag that an interface-detection circuit drives from outside. Writing a code starts a command and raises a one-cycle start pulse. An external done input returns the code to zero, which means idle. All register access uses a simple synchronous port with write and read strobes, and read data appears one clock after the read strobe.

Top module: `paged_addr_composer`

## Requirements
- R1: After reset the paging register reads 0x80 (paging enabled, page 0), the command code is 0 and the start pulse is low, so host address 0x2B maps to effective address 0x03.
- R2: A write to any effective address whose low three bits are 000 loads the paging register: the flag comes from wdata bit 7 and the page from wdata bits 2:0. Reads return {flag, 0000, page}; wdata bits 6:3 are ignored.
- R3: With the flag at 1, eff_addr_o bits 5:3 equal the page field and bits 2:0 equal host_addr_i bits 2:0, for all eight pages.
- R4: With the flag at 0, eff_addr_o equals host_addr_i for all six bits, whatever the page field holds.
- R5: A read at effective address 0x01 returns {det_busy_i, 0, command code}, where the command code is in bits 5:0. The busy bit follows the input at the cycle of the read.
- R6: A write to effective address 0x01 loads wdata bits 5:0 as the command code and ignores bits 7:6. cmd_start_o is high for exactly the one cycle after the write, and cmd_code_o shows the new code in that same cycle.
- R7: cmd_done_i clears the command code to 0 in the cycle after it is asserted. A command write in the same cycle wins over the clear.
- R8: Reads at effective addresses other than the paging register and 0x01 return 0x00.
- R9: With paging disabled, reads at any mirror address (0x08 through 0x38 in steps of 8) still return the paging register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| host_addr_i | input | 6 | Host register address from the pins or the latch |
| wr_i | input | 1 | Write strobe |
| rd_i | input | 1 | Read strobe |
| wdata_i | input | 8 | Write data |
| rdata_o | output | 8 | Read data, valid the cycle after rd_i |
| eff_addr_o | output | 6 | Composed effective register address |
| det_busy_i | input | 1 | Interface detection ongoing (1) or finished (0) |
| cmd_done_i | input | 1 | Current command has finished |
| cmd_code_o | output | 6 | Command code currently held |
| cmd_start_o | output | 1 | One-cycle pulse after a command write |

## Verification
A corrupted paging flag or page field shows at once on eff_addr_o, because the mux is combinational: every later host address lands in the wrong place. The bench walks all eight pages in both modes and compares the composed address to values worked out by hand. A wrong command code or a missed clear shows on cmd_code_o one cycle after the write or done strobe, and again on the next read at 0x01. A faulty decode shows as a stray value in rdata_o one cycle after the read strobe, at mirror and unmapped addresses in either mode.

// File: rtl/pac_pkg.sv
package pac_pkg;
   localparam int unsigned PAC_ADDR_W   = 6;
   localparam int unsigned PAC_PAGE_W   = 3;
   localparam int unsigned PAC_DATA_W   = 8;
   localparam int unsigned PAC_CMD_W    = 6;
   localparam int unsigned PAC_CMD_ADDR = 1;

   typedef enum logic [1:0] {
      SEL_NONE = 2'd0,
      SEL_PAGE = 2'd1,
      SEL_CMD  = 2'd2
   } pac_sel_e;
endpackage

// File: rtl/pac_page_reg.sv
module pac_page_reg #(
   parameter int unsigned DATA_W = 8,
   parameter int unsigned PAGE_W = 3
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_i,
   input  logic [DATA_W-1:0] wdata_i,
   output logic              use_page_o,
   output logic [PAGE_W-1:0] page_o,
   output logic [DATA_W-1:0] rd_byte_o
);
   localparam int unsigned RSVD_W = DATA_W - PAGE_W - 1;

   initial begin
      if (DATA_W < PAGE_W + 2) $error("pac_page_reg: DATA_W too small for flag and page");
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         use_page_o <= 1'b1;
         page_o     <= '0;
      end else if (wr_i) begin
         use_page_o <= wdata_i[DATA_W-1];
         page_o     <= wdata_i[PAGE_W-1:0];
      end
   end

   assign rd_byte_o = {use_page_o, {RSVD_W{1'b0}}, page_o};

   AST_PAGE_WRITE_LOADS: assert property (@(posedge clk) disable iff (!rst_n)
      wr_i |=> (rd_byte_o == ($past(wdata_i) & {1'b1, {RSVD_W{1'b0}}, {PAGE_W{1'b1}}}))); // R2

   AST_PAGE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
      !wr_i |=> $stable(rd_byte_o)); // R2
endmodule

// File: rtl/pac_addr_mux.sv
module pac_addr_mux #(
   parameter int unsigned ADDR_W = 6,
   parameter int unsigned PAGE_W = 3
) (
   input  logic              use_page_i,
   input  logic [PAGE_W-1:0] page_i,
   input  logic [ADDR_W-1:0] host_addr_i,
   output logic [ADDR_W-1:0] eff_addr_o
);
   localparam int unsigned LOW_W = ADDR_W - PAGE_W;

   initial begin
      if (LOW_W < 1) $error("pac_addr_mux: ADDR_W must exceed PAGE_W");
   end

   always_comb begin
      if (use_page_i) eff_addr_o = {page_i, host_addr_i[LOW_W-1:0]};
      else            eff_addr_o = host_addr_i;
   end

   always_comb begin
      if (!use_page_i) AST_UNPAGED_PASS: assert (eff_addr_o == host_addr_i); // R4
   end
endmodule

// File: rtl/pac_cmd_reg.sv
module pac_cmd_reg #(
   parameter int unsigned DATA_W = 8,
   parameter int unsigned CMD_W  = 6
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_i,
   input  logic [DATA_W-1:0] wdata_i,
   input  logic              done_i,
   input  logic              busy_i,
   output logic [CMD_W-1:0]  code_o,
   output logic              start_o,
   output logic [DATA_W-1:0] rd_byte_o
);
   localparam int unsigned PAD_W = DATA_W - CMD_W - 1;

   initial begin
      if (DATA_W < CMD_W + 2) $error("pac_cmd_reg: DATA_W too small for busy and code");
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         code_o  <= '0;
         start_o <= 1'b0;
      end else begin
         start_o <= wr_i;
         if (wr_i)        code_o <= wdata_i[CMD_W-1:0];
         else if (done_i) code_o <= '0;
      end
   end

   assign rd_byte_o = {busy_i, {PAD_W{1'b0}}, code_o};

   AST_CMD_WRITE_WINS: assert property (@(posedge clk) disable iff (!rst_n)
      wr_i |=> (code_o == $past(wdata_i[CMD_W-1:0])) && start_o); // R6

   AST_CMD_DONE_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
      (done_i && !wr_i) |=> (code_o == '0) && !start_o); // R7
endmodule

// File: rtl/paged_addr_composer.sv
module paged_addr_composer
   import pac_pkg::*;
#(
   parameter int unsigned ADDR_W   = PAC_ADDR_W,
   parameter int unsigned PAGE_W   = PAC_PAGE_W,
   parameter int unsigned DATA_W   = PAC_DATA_W,
   parameter int unsigned CMD_W    = PAC_CMD_W,
   parameter int unsigned CMD_ADDR = PAC_CMD_ADDR,
   parameter bit          RD_REG   = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [ADDR_W-1:0] host_addr_i,
   input  logic              wr_i,
   input  logic              rd_i,
   input  logic [DATA_W-1:0] wdata_i,
   output logic [DATA_W-1:0] rdata_o,
   output logic [ADDR_W-1:0] eff_addr_o,
   input  logic              det_busy_i,
   input  logic              cmd_done_i,
   output logic [CMD_W-1:0]  cmd_code_o,
   output logic              cmd_start_o
);
   localparam int unsigned LOW_W = ADDR_W - PAGE_W;

   initial begin
      if (CMD_ADDR % (1 << LOW_W) == 0) $error("composer: CMD_ADDR collides with a page mirror");
      if (CMD_ADDR >= (1 << ADDR_W))    $error("composer: CMD_ADDR outside address space");
   end

   logic              use_page;
   logic [PAGE_W-1:0] page;
   logic [DATA_W-1:0] page_byte, cmd_byte, rd_next;
   pac_sel_e          sel;

   always_comb begin
      if (eff_addr_o[LOW_W-1:0] == '0)              sel = SEL_PAGE;
      else if (eff_addr_o == ADDR_W'(CMD_ADDR))     sel = SEL_CMD;
      else                                          sel = SEL_NONE;
   end

   pac_page_reg #(.DATA_W(DATA_W), .PAGE_W(PAGE_W)) u_page (
      .clk        (clk),
      .rst_n      (rst_n),
      .wr_i       (wr_i && (sel == SEL_PAGE)),
      .wdata_i    (wdata_i),
      .use_page_o (use_page),
      .page_o     (page),
      .rd_byte_o  (page_byte)
   );

   pac_addr_mux #(.ADDR_W(ADDR_W), .PAGE_W(PAGE_W)) u_mux (
      .use_page_i  (use_page),
      .page_i      (page),
      .host_addr_i (host_addr_i),
      .eff_addr_o  (eff_addr_o)
   );

   pac_cmd_reg #(.DATA_W(DATA_W), .CMD_W(CMD_W)) u_cmd (
      .clk       (clk),
      .rst_n     (rst_n),
      .wr_i      (wr_i && (sel == SEL_CMD)),
      .wdata_i   (wdata_i),
      .done_i    (cmd_done_i),
      .busy_i    (det_busy_i),
      .code_o    (cmd_code_o),
      .start_o   (cmd_start_o),
      .rd_byte_o (cmd_byte)
   );

   always_comb begin
      unique case (sel)
         SEL_PAGE: rd_next = page_byte;
         SEL_CMD:  rd_next = cmd_byte;
         default:  rd_next = '0;
      endcase
   end

   generate
      if (RD_REG) begin : g_rd_reg
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)    rdata_o <= '0;
            else if (rd_i) rdata_o <= rd_next;
         end

         AST_MIRROR_READ: assert property (@(posedge clk) disable iff (!rst_n)
            (rd_i && !wr_i && (host_addr_i[LOW_W-1:0] == '0) && !use_page)
            |=> (rdata_o == $past(page_byte))); // R9

         AST_UNMAPPED_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
            (rd_i && (eff_addr_o[LOW_W-1:0] != '0) && (eff_addr_o != ADDR_W'(CMD_ADDR)))
            |=> (rdata_o == '0)); // R8
      end else begin : g_rd_comb
         assign rdata_o = rd_i ? rd_next : '0;
      end
   endgenerate
endmodule

// File: tb/paged_addr_composer_bench.sv
module paged_addr_composer_bench;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic [5:0] host_addr = '0;
   logic       wr = 1'b0, rd = 1'b0;
   logic [7:0] wdata = '0;
   logic [7:0] rdata;
   logic [5:0] eff_addr;
   logic       busy = 1'b0, done = 1'b0;
   logic [5:0] cmd_code;
   logic       cmd_start;

   int n_checks = 0;
   int n_fail   = 0;
   logic       start_seen;
   logic [7:0] rv;

   always #4 clk = ~clk;

   paged_addr_composer u_paged_addr_composer (
      .clk(clk), .rst_n(rst_n), .host_addr_i(host_addr), .wr_i(wr), .rd_i(rd),
      .wdata_i(wdata), .rdata_o(rdata), .eff_addr_o(eff_addr), .det_busy_i(busy),
      .cmd_done_i(done), .cmd_code_o(cmd_code), .cmd_start_o(cmd_start)
   );

   // {flag, page[2:0], host[5:0], expected eff[5:0]}
   localparam logic [15:0] VEC [16] = '{
      {1'b1, 3'd0, 6'h3D, 6'h05}, {1'b1, 3'd1, 6'h02, 6'h0A},
      {1'b1, 3'd2, 6'h17, 6'h17}, {1'b1, 3'd3, 6'h00, 6'h18},
      {1'b1, 3'd4, 6'h3F, 6'h27}, {1'b1, 3'd5, 6'h11, 6'h29},
      {1'b1, 3'd6, 6'h26, 6'h36}, {1'b1, 3'd7, 6'h08, 6'h38},
      {1'b0, 3'd0, 6'h3D, 6'h3D}, {1'b0, 3'd1, 6'h02, 6'h02},
      {1'b0, 3'd2, 6'h17, 6'h17}, {1'b0, 3'd3, 6'h00, 6'h00},
      {1'b0, 3'd4, 6'h3F, 6'h3F}, {1'b0, 3'd5, 6'h11, 6'h11},
      {1'b0, 3'd6, 6'h26, 6'h26}, {1'b0, 3'd7, 6'h08, 6'h08}
   };

   task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
      n_checks++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: actual %02h expected %02h", req, act, exp);
      end
   endtask

   task automatic reg_wr(input logic [5:0] a, input logic [7:0] d);
      @(negedge clk);
      host_addr = a; wdata = d; wr = 1'b1;
      @(negedge clk);
      wr = 1'b0;
      start_seen = cmd_start;
   endtask

   task automatic reg_rd(input logic [5:0] a, output logic [7:0] d);
      @(negedge clk);
      host_addr = a; rd = 1'b1;
      @(negedge clk);
      rd = 1'b0;
      d = rdata;
   endtask

   initial begin
      repeat (50000) @(posedge clk);
      n_checks++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R1 reset state
      check("R1 code", {2'b0, cmd_code}, 8'h00);
      check("R1 start", {7'b0, cmd_start}, 8'h00);
      host_addr = 6'h2B; #1;
      check("R1 eff", {2'b0, eff_addr}, 8'h03);
      reg_rd(6'h00, rv); check("R1 page", rv, 8'h80);

      // R3/R4 table walk over all pages, both modes
      foreach (VEC[i]) begin
         reg_wr(6'h00, {VEC[i][15], 4'b0000, VEC[i][14:12]});
         @(negedge clk);
         host_addr = VEC[i][11:6]; #1;
         check(VEC[i][15] ? "R3 paged eff" : "R4 unpaged eff", {2'b0, eff_addr}, {2'b0, VEC[i][5:0]});
      end

      // R2 reserved bits ignored, write via a mirror in paged mode
      reg_wr(6'h00, 8'hFD);
      reg_rd(6'h00, rv); check("R2 page rsvd", rv, 8'h85);
      reg_rd(6'h03, rv); check("R8 unmapped paged", rv, 8'h00);
      reg_wr(6'h00, 8'h83);  // eff 0x28 -> page reg, page 3
      reg_rd(6'h05, rv); check("R8 unmapped page3", rv, 8'h00);

      // R9 mirrors in unpaged mode
      reg_wr(6'h00, 8'h06);
      for (int m = 1; m < 8; m++) begin
         reg_rd(6'(m * 8), rv); check("R9 mirror", rv, 8'h06);
      end
      reg_rd(6'h02, rv); check("R8 unmapped", rv, 8'h00);

      // R5 command read with busy
      busy = 1'b1;
      reg_rd(6'h01, rv); check("R5 busy", rv, 8'h80);
      busy = 1'b0;

      // R6 command write
      reg_wr(6'h01, 8'hE5);
      check("R6 start", {7'b0, start_seen}, 8'h01);
      check("R6 code", {2'b0, cmd_code}, 8'h25);
      @(negedge clk);
      check("R6 start one cycle", {7'b0, cmd_start}, 8'h00);
      busy = 1'b1;
      reg_rd(6'h01, rv); check("R5 read code", rv, 8'hA5);
      busy = 1'b0;

      // R7 done clears, write wins
      @(negedge clk); done = 1'b1;
      @(negedge clk); done = 1'b0;
      check("R7 clear", {2'b0, cmd_code}, 8'h00);
      @(negedge clk);
      host_addr = 6'h01; wdata = 8'h12; wr = 1'b1; done = 1'b1;
      @(negedge clk);
      wr = 1'b0; done = 1'b0;
      check("R7 write wins", {2'b0, cmd_code}, 8'h12);
      reg_rd(6'h01, rv); check("R7 readback", rv, 8'h12);

      // R1 reset restores
      @(negedge clk); rst_n = 1'b0;
      @(negedge clk); rst_n = 1'b1;
      reg_rd(6'h08, rv); check("R1 page after reset", rv, 8'h80);

      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
   end
endmodule